// File: doc/BRIEF.md
# Per-Class Instruction Issue Scheduler

This block sits between an instruction buffer and a scoreboard inside a compute core. Each instruction word carries a class opcode in its top four bits. The opcode routes the word to one of four independent issue machines: DMA, matrix unit, vector unit and router. Each machine holds one instruction. It waits until the resources that its class depends on are free, offers the instruction to the scoreboard, and then waits for its execution unit to report completion before it takes a new word.

Because the machines are independent, a long DMA transfer does not hold back vector or router work. The buffer interface still delivers words in order, so a word whose class machine is occupied stalls the buffer head. When several machines offer work in the same cycle, a fixed priority picks one. An offer that the scoreboard has not yet accepted keeps the port until it is taken. A run-complete flag from the controller freezes all intake and issue.

Top module: `sched_issue_top`

## Requirements
- R1: After reset, sb_valid_o and err_o are 0, and ibuf_ready_o is 1 while run_done_i is 0.
- R2: Opcode bits [31:28] select the class as follows: 4'h1 is DMA, 4'h2 is matrix, 4'h3 is vector and 4'h4 is router. sb_class_o reports the class as 0 for DMA, 1 for matrix, 2 for vector and 3 for router, and sb_data_o carries the unchanged word.
- R3: A word with any other opcode is accepted and dropped. err_o is 1 for exactly the cycle after it is accepted, and the word never reaches the scoreboard.
- R4: A held instruction waits while the busy bit of its own unit is set (unit_busy_i bit index equals the class code). Matrix and vector instructions also wait while rf_busy_i is 1. DMA and router instructions ignore rf_busy_i.
- R5: With its resources free, a word accepted at clock edge N is offered on sb_valid_o after edge N+1. If sb_ready_i is 1 it is accepted at edge N+2.
- R6: When several classes become ready in the same cycle, they are offered in the order DMA, matrix, vector, router, one per accepting cycle.
- R7: While sb_valid_o is 1 and sb_ready_i is 0, sb_valid_o, sb_data_o and sb_class_o stay unchanged in the next cycle, even if a higher-priority class becomes ready, unless run_done_i is 1.
- R8: From acceptance until its unit_done_i bit pulses, a class takes no new word, and ibuf_ready_o is 0 while the buffer head holds that class.
- R9: A class that is waiting for completion does not block the intake or issue of other classes.
- R10: While run_done_i is 1, ibuf_ready_o and sb_valid_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_done_i | input | 1 | Controller flag: the run is complete, stop intake and issue |
| ibuf_valid_i | input | 1 | Instruction buffer head is valid |
| ibuf_data_i | input | 32 | Instruction word; opcode in bits [31:28] |
| ibuf_ready_o | output | 1 | Head word is taken this cycle when valid |
| unit_busy_i | input | 4 | Per-class unit busy, indexed by class code |
| rf_busy_i | input | 1 | Register file busy; gates matrix and vector classes |
| unit_done_i | input | 4 | Per-class completion pulse, indexed by class code |
| sb_valid_o | output | 1 | Instruction offered to the scoreboard |
| sb_ready_i | input | 1 | Scoreboard accepts the offered instruction |
| sb_data_o | output | 32 | Offered instruction word |
| sb_class_o | output | 2 | Class code of the offered instruction |
| err_o | output | 1 | One-cycle pulse after an undefined opcode is dropped |

## Verification
A class machine stuck in the wrong state shows at the ports within a few cycles. If it is stuck busy, ibuf_ready_o stays low for that opcode after its done pulse. If it is stuck idle or checking, the expected scoreboard offer is missing two cycles after acceptance. A wrong priority or a lost hold lock shows as an out-of-order or altered word the first time two classes compete, and the scoreboard queue in the bench catches it at the accepting edge. A faulty decode shows either as a wrong class code on the offered word or as an err_o pulse on a legal opcode.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_CLASS = 4;
  localparam int CLS_W     = $clog2(NUM_CLASS);
  localparam int OP_W      = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_DMA = 2'd0,
    CLS_MPU = 2'd1,
    CLS_VPU = 2'd2,
    CLS_RTR = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } fsm_st_e;

  localparam logic [OP_W-1:0] OPC_DMA = 4'h1;
  localparam logic [OP_W-1:0] OPC_MPU = 4'h2;
  localparam logic [OP_W-1:0] OPC_VPU = 4'h3;
  localparam logic [OP_W-1:0] OPC_RTR = 4'h4;

  function automatic logic class_uses_rf(input int c);
    return (c == int'(CLS_MPU)) || (c == int'(CLS_VPU));
  endfunction
endpackage

// File: rtl/sched_decode.sv
module sched_decode
  import sched_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0]   instr_i,
  output logic [NUM_CLASS-1:0] cls_oh_o,
  output logic                 legal_o
);
  logic [OP_W-1:0] opc;
  assign opc = instr_i[INSTR_W-1 -: OP_W];

  always_comb begin
    cls_oh_o = '0;
    unique case (opc)
      OPC_DMA: cls_oh_o[CLS_DMA] = 1'b1;
      OPC_MPU: cls_oh_o[CLS_MPU] = 1'b1;
      OPC_VPU: cls_oh_o[CLS_VPU] = 1'b1;
      OPC_RTR: cls_oh_o[CLS_RTR] = 1'b1;
      default: cls_oh_o = '0;
    endcase
    legal_o = |cls_oh_o;
  end
endmodule

// File: rtl/sched_class_fsm.sv
module sched_class_fsm
  import sched_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter bit USES_RF = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               unit_busy_i,
  input  logic               rf_busy_i,
  input  logic               halt_i,
  input  logic               gnt_i,
  input  logic               sb_ready_i,
  input  logic               done_i,
  output logic               idle_o,
  output logic               req_o,
  output logic [INSTR_W-1:0] instr_o
);
  fsm_st_e state_q, state_d;
  logic [INSTR_W-1:0] instr_q;
  logic blocked;

  assign blocked = unit_busy_i | (USES_RF & rf_busy_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load_i) state_d = ST_CHECK;
      ST_CHECK: if (!blocked) state_d = ST_ISSUE;
      ST_ISSUE: if (gnt_i && sb_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      instr_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && load_i) instr_q <= instr_i;
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign req_o   = (state_q == ST_ISSUE) && !halt_i;
  assign instr_o = instr_q;
endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter #(
  parameter int N     = 4,
  parameter int W     = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [W-1:0]     data_i [N],
  input  logic             sb_ready_i,
  output logic [N-1:0]     gnt_o,
  output logic             valid_o,
  output logic [W-1:0]     data_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             hold_q;
  logic [IDX_W-1:0] hold_idx_q;
  logic [IDX_W-1:0] prio_idx;

  // lowest index wins
  always_comb begin
    prio_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) prio_idx = IDX_W'(i);
    end
  end

  // keep a pending offer on the port until it is taken
  always_comb begin
    if (hold_q && req_i[hold_idx_q]) idx_o = hold_idx_q;
    else                             idx_o = prio_idx;
    valid_o = |req_i;
    gnt_o   = valid_o ? (N'(1) << idx_o) : '0;
    data_o  = data_i[idx_o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= valid_o && !sb_ready_i;
      hold_idx_q <= idx_o;
    end
  end
endmodule

// File: rtl/sched_issue_top.sv
module sched_issue_top
  import sched_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_done_i,
  input  logic               ibuf_valid_i,
  input  logic [INSTR_W-1:0] ibuf_data_i,
  output logic               ibuf_ready_o,
  input  logic [3:0]         unit_busy_i,
  input  logic               rf_busy_i,
  input  logic [3:0]         unit_done_i,
  output logic               sb_valid_o,
  input  logic               sb_ready_i,
  output logic [INSTR_W-1:0] sb_data_o,
  output logic [1:0]         sb_class_o,
  output logic               err_o
);
  logic [NUM_CLASS-1:0] cls_oh, cls_idle, cls_req, cls_gnt, cls_load;
  logic [INSTR_W-1:0]   cls_instr [NUM_CLASS];
  logic                 legal, accept, err_q;
  logic [CLS_W-1:0]     arb_idx;

  sched_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr_i  (ibuf_data_i),
    .cls_oh_o (cls_oh),
    .legal_o  (legal)
  );

  assign ibuf_ready_o = !run_done_i && (!legal || |(cls_oh & cls_idle));
  assign accept       = ibuf_valid_i && ibuf_ready_o;
  assign cls_load     = accept ? cls_oh : '0;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    sched_class_fsm #(
      .INSTR_W (INSTR_W),
      .USES_RF (class_uses_rf(c))
    ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (cls_load[c]),
      .instr_i     (ibuf_data_i),
      .unit_busy_i (unit_busy_i[c]),
      .rf_busy_i   (rf_busy_i),
      .halt_i      (run_done_i),
      .gnt_i       (cls_gnt[c]),
      .sb_ready_i  (sb_ready_i),
      .done_i      (unit_done_i[c]),
      .idle_o      (cls_idle[c]),
      .req_o       (cls_req[c]),
      .instr_o     (cls_instr[c])
    );
  end

  sched_arbiter #(.N(NUM_CLASS), .W(INSTR_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (cls_req),
    .data_i     (cls_instr),
    .sb_ready_i (sb_ready_i),
    .gnt_o      (cls_gnt),
    .valid_o    (sb_valid_o),
    .data_o     (sb_data_o),
    .idx_o      (arb_idx)
  );

  assign sb_class_o = arb_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept && !legal;
  end
  assign err_o = err_q;
endmodule

// File: rtl/sched_issue_chk.sv
module sched_issue_chk #(
  parameter int INSTR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_done_i,
  input logic               ibuf_valid_i,
  input logic [INSTR_W-1:0] ibuf_data_i,
  input logic               ibuf_ready_o,
  input logic               sb_valid_o,
  input logic               sb_ready_i,
  input logic [INSTR_W-1:0] sb_data_o,
  input logic [1:0]         sb_class_o,
  input logic               err_o,
  input logic [3:0]         gnt
);
  logic [3:0] opc;
  logic       opc_bad;
  assign opc     = ibuf_data_i[INSTR_W-1 -: 4];
  assign opc_bad = (opc == 4'h0) || (opc > 4'h4);

  // R7
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_valid_o && !sb_ready_i && !run_done_i) |=>
      (run_done_i || (sb_valid_o && $stable(sb_data_o) && $stable(sb_class_o))));

  // R10
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_done_i |-> (!sb_valid_o && !ibuf_ready_o));

  // R3
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(ibuf_valid_i && ibuf_ready_o && opc_bad));

  // R6
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && (sb_valid_o == (gnt != 4'd0)));

  // R2
  class_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_valid_o |-> (sb_data_o[INSTR_W-1 -: 4] == {2'b00, sb_class_o} + 4'h1));
endmodule

bind sched_issue_top sched_issue_chk #(.INSTR_W(INSTR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_done_i   (run_done_i),
  .ibuf_valid_i (ibuf_valid_i),
  .ibuf_data_i  (ibuf_data_i),
  .ibuf_ready_o (ibuf_ready_o),
  .sb_valid_o   (sb_valid_o),
  .sb_ready_i   (sb_ready_i),
  .sb_data_o    (sb_data_o),
  .sb_class_o   (sb_class_o),
  .err_o        (err_o),
  .gnt          (cls_gnt)
);

// File: tb/sched_issue_top_tb.sv
module sched_issue_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_done = 1'b0;
  logic        ibuf_valid = 1'b0;
  logic [31:0] ibuf_data = '0;
  logic        ibuf_ready;
  logic [3:0]  unit_busy = '0;
  logic        rf_busy = 1'b0;
  logic [3:0]  unit_done = '0;
  logic        sb_valid;
  logic        sb_ready = 1'b0;
  logic [31:0] sb_data;
  logic [1:0]  sb_class;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  logic [33:0] exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sched_issue_top u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .run_done_i   (run_done),
    .ibuf_valid_i (ibuf_valid),
    .ibuf_data_i  (ibuf_data),
    .ibuf_ready_o (ibuf_ready),
    .unit_busy_i  (unit_busy),
    .rf_busy_i    (rf_busy),
    .unit_done_i  (unit_done),
    .sb_valid_o   (sb_valid),
    .sb_ready_i   (sb_ready),
    .sb_data_o    (sb_data),
    .sb_class_o   (sb_class),
    .err_o        (err)
  );

  task automatic chk(input logic ok, input string req, input logic [33:0] act,
                     input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] cls, input logic [31:0] w);
    exp_q.push_back({cls, w});
  endtask

  // presents a word; sets inputs after a rising edge, checks ready, lets it be taken
  task automatic send(input logic [31:0] w);
    @(posedge clk); #1;
    ibuf_valid = 1'b1;
    ibuf_data  = w;
    @(negedge clk);
    chk(ibuf_ready == 1'b1, "R8 intake open", {33'd0, ibuf_ready}, 34'd1);
    @(posedge clk); #1;
    ibuf_valid = 1'b0;
  endtask

  task automatic pulse_done(input logic [3:0] m);
    @(posedge clk); #1;
    unit_done = m;
    @(posedge clk); #1;
    unit_done = '0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare each accepted offer against the expected queue
  always @(negedge clk) begin
    if (rst_n && sb_valid && sb_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected issue", {sb_class, sb_data}, 34'd0);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk({sb_class, sb_data} == e, "R2/R6 issue order", {sb_class, sb_data}, e);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!sb_valid && !err && ibuf_ready, "R1 reset state",
        {31'd0, sb_valid, err, ibuf_ready}, 34'd1);

    // R5: DMA timing with free resources
    sb_ready = 1'b1;
    push_exp(2'd0, 32'h1000_00A1);
    send(32'h1000_00A1);
    @(negedge clk);
    chk(!sb_valid, "R5 not yet offered", {33'd0, sb_valid}, 34'd0);
    @(negedge clk);
    chk(sb_valid && sb_class == 2'd0, "R5 offered two edges after accept",
        {31'd0, sb_valid, sb_class}, {31'd0, 1'b1, 2'd0});
    @(negedge clk);
    chk(!sb_valid, "R5 taken once", {33'd0, sb_valid}, 34'd0);

    // R8: DMA busy until done; R9: vector proceeds meanwhile
    @(posedge clk); #1;
    ibuf_valid = 1'b1;
    ibuf_data  = 32'h1000_00A2;
    @(negedge clk);
    chk(!ibuf_ready, "R8 class occupied", {33'd0, ibuf_ready}, 34'd0);
    @(posedge clk); #1 ibuf_valid = 1'b0;
    push_exp(2'd2, 32'h3000_00C1);
    send(32'h3000_00C1);
    wait_neg(3);
    chk(exp_q.size() == 0, "R9 vector issued past waiting DMA", 34'(exp_q.size()), 34'd0);
    pulse_done(4'b0101);
    @(posedge clk); #1 ibuf_data = 32'h1000_00A2;
    @(negedge clk);
    chk(ibuf_ready, "R8 reopened after done", {33'd0, ibuf_ready}, 34'd1);

    // R3: undefined opcode
    send(32'h7000_0BAD);
    @(negedge clk);
    chk(err, "R3 err pulse", {33'd0, err}, 34'd1);
    @(negedge clk);
    chk(!err && !sb_valid, "R3 err one cycle, nothing issued", {32'd0, err, sb_valid}, 34'd0);

    // R4: matrix gated by its unit and by the register file
    unit_busy[1] = 1'b1;
    send(32'h2000_00B1);
    wait_neg(3);
    chk(!sb_valid, "R4 matrix waits on unit busy", {33'd0, sb_valid}, 34'd0);
    @(posedge clk); #1 unit_busy[1] = 1'b0; rf_busy = 1'b1;
    wait_neg(3);
    chk(!sb_valid, "R4 matrix waits on rf busy", {33'd0, sb_valid}, 34'd0);
    // R4: DMA ignores rf busy
    push_exp(2'd0, 32'h1000_00A3);
    send(32'h1000_00A3);
    wait_neg(2);
    chk(sb_valid && sb_class == 2'd0, "R4 DMA not gated by rf busy",
        {31'd0, sb_valid, sb_class}, {31'd0, 1'b1, 2'd0});
    push_exp(2'd1, 32'h2000_00B1);
    @(posedge clk); #1 rf_busy = 1'b0;
    wait_neg(3);
    chk(exp_q.size() == 0, "R4 matrix issued after release", 34'(exp_q.size()), 34'd0);
    pulse_done(4'b1111);

    // R6: all four become ready together
    unit_busy = 4'hF;
    send(32'h4000_00D1);
    send(32'h3000_00C2);
    send(32'h2000_00B2);
    send(32'h1000_00A4);
    push_exp(2'd0, 32'h1000_00A4);
    push_exp(2'd1, 32'h2000_00B2);
    push_exp(2'd2, 32'h3000_00C2);
    push_exp(2'd3, 32'h4000_00D1);
    @(posedge clk); #1 unit_busy = 4'h0;
    wait_neg(6);
    chk(exp_q.size() == 0, "R6 all four issued in priority order", 34'(exp_q.size()), 34'd0);
    pulse_done(4'b1111);

    // R7: pending router offer keeps the port over a later DMA
    sb_ready = 1'b0;
    send(32'h4000_00D2);
    send(32'h1000_00A5);
    wait_neg(2);
    chk(sb_valid && sb_class == 2'd3 && sb_data == 32'h4000_00D2, "R7 offer held",
        {sb_class, sb_data}, {2'd3, 32'h4000_00D2});
    push_exp(2'd3, 32'h4000_00D2);
    push_exp(2'd0, 32'h1000_00A5);
    @(posedge clk); #1 sb_ready = 1'b1;
    wait_neg(3);
    chk(exp_q.size() == 0, "R7 held offer drained first", 34'(exp_q.size()), 34'd0);
    pulse_done(4'b1111);

    // R10: run complete freezes intake and issue
    sb_ready = 1'b0;
    send(32'h2000_00B3);
    wait_neg(2);
    chk(sb_valid, "R10 offer before halt", {33'd0, sb_valid}, 34'd1);
    @(posedge clk); #1 run_done = 1'b1; sb_ready = 1'b1;
    ibuf_valid = 1'b1;
    ibuf_data  = 32'h3000_00C3;
    @(negedge clk);
    chk(!sb_valid && !ibuf_ready, "R10 halted", {32'd0, sb_valid, ibuf_ready}, 34'd0);
    wait_neg(2);
    chk(!sb_valid, "R10 stays halted", {33'd0, sb_valid}, 34'd0);
    push_exp(2'd1, 32'h2000_00B3);
    @(posedge clk); #1 run_done = 1'b0; ibuf_valid = 1'b0;
    wait_neg(2);
    chk(exp_q.size() == 0, "R10 resumes after release", 34'(exp_q.size()), 34'd0);

    finish_run();
  end
endmodule